// File: doc/BRIEF.md
# HyperBus Latency-Aware Transaction Sequencer

This block is the host-side sequencer for one read or write burst on an 8-bit double-data-rate memory link of the HyperBus kind. A user asks for a transaction through a request/acknowledge port that carries the 48-bit command-address word and a burst length in 16-bit words. The sequencer then runs the bus through four phases. It asserts chip select and sends the command-address. It waits out the initial access latency. It moves the data words. Finally it releases chip select and waits out a recovery gap before it takes the next request.

The sequencer runs on one internal clock at twice the bus clock rate. Each internal cycle is one half-period of the bus clock, so one byte moves per internal cycle and the bus clock output is a level produced by that clock. The memory drives RWDS while the command-address is sent. Its level, sampled in the last command-address cycle, chooses between the plain latency and the doubled latency. A fixed-latency configuration bit makes the sequencer ignore RWDS and always use the doubled latency. Bit 47 of the command-address word sets the direction, and the sequencer uses it to decide who drives DQ and RWDS in the data phase.

Top module: `hbus_seq`

## Requirements
- R1: In the six internal cycles that follow the cycle in which `req_ack` is high, the block drives the command-address bytes on `dq_o`, one byte per cycle, bits 47:40 first and bits 7:0 last. During these cycles `dq_oe` is 1 and `rwds_oe` is 0.
- R2: `ck` is 0 whenever `cs_n` is 1. While `cs_n` is 0, `ck` is 0 in the first command-address cycle and inverts on every internal cycle after that.
- R3: With `cfg_fixed` at 0, the block samples `rwds_i` only at the end of the sixth command-address cycle. If it is 1, 4×`cfg_lat` latency cycles follow, during which `dq_oe` and `rwds_oe` are 0. If it is 0, 2×`cfg_lat` latency cycles follow. When `cfg_lat` is 0 there are no latency cycles.
- R4: With `cfg_fixed` at 1, the level of `rwds_i` has no effect, and the latency is always 4×`cfg_lat` internal cycles.
- R5: A write data phase lasts 2×W internal cycles. For each word, the cycle with bits 15:8 on `dq_o` comes first and `wr_take` is high in that cycle. The next cycle carries bits 7:0. Throughout the data phase `dq_oe` and `rwds_oe` are 1 and `rwds_o` is 0, which means no byte is masked.
- R6: In a read data phase `dq_oe` and `rwds_oe` are 0. `rd_valid` is high for one cycle after each pair of data cycles, and `rd_data` then holds {first byte, second byte} as sampled from `dq_i` at the ends of those two cycles.
- R7: `cs_n` returns to 1 in the internal cycle right after the last data byte.
- R8: Let `cs_n` return to 1 in cycle E, with a request already pending. Then `req_ack` rises in cycle E+`cfg_rwr` and not earlier, so `cs_n` stays high for at least `cfg_rwr`+1 cycles between transactions.
- R9: `req_ca` bit 47 set to 1 selects a read and set to 0 selects a write.
- R10: After reset `cs_n` is 1, and `ck`, `dq_oe`, `rwds_oe`, `rd_valid`, `wr_take` and `req_ack` (with no request) are 0.
- R11: A burst length of 0 is carried out as a burst of one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, twice the bus clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_lat | input | LAT_W | Latency count in bus clock cycles |
| cfg_fixed | input | 1 | 1: ignore RWDS, always doubled latency |
| cfg_rwr | input | RWR_W | Recovery gap in internal cycles |
| req_valid | input | 1 | Transaction request |
| req_ack | output | 1 | Request accepted this cycle |
| req_ca | input | 48 | Command-address word, bit 47 = read |
| req_len | input | LEN_W | Burst length in 16-bit words |
| wr_data | input | 16 | Write word at the head of the user's queue |
| wr_take | output | 1 | Write word consumed this cycle |
| rd_data | output | 16 | Assembled read word |
| rd_valid | output | 1 | `rd_data` valid strobe |
| cs_n | output | 1 | Chip select, active low |
| ck | output | 1 | Bus clock |
| dq_o | output | 8 | DQ output byte |
| dq_oe | output | 1 | DQ output enable |
| dq_i | input | 8 | DQ input byte |
| rwds_o | output | 1 | RWDS output (write mask) |
| rwds_oe | output | 1 | RWDS output enable |
| rwds_i | input | 1 | RWDS input |

## Verification
The bench sweeps every combination of direction, latency count 0 to 3, burst length 1 to 3, fixed mode and RWDS level, repeated for three recovery settings, and also runs zero-length bursts. The bench drives RWDS to the opposite level in every cycle except the sampling cycle. A design that samples in the wrong cycle, or that reads RWDS in fixed mode, therefore starts its data phase 2×`cfg_lat` cycles early or late, and the per-cycle checks on `dq_o` and `cs_n` catch this. Zero latency catches an off-by-one or an underflow in the latency counter, which would hang or insert stray cycles. Back-to-back requests catch a recovery gap that is one cycle short or long, and read data that comes from a new pattern each cycle catches bytes that are swapped or captured one cycle off.

// File: rtl/hbus_pkg.sv
`timescale 1ns/1ps
package hbus_pkg;
  localparam int CA_W     = 48;
  localparam int CA_BYTES = CA_W / 8;
  localparam int CA_RD_BIT = CA_W - 1;
  localparam int WORD_W   = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CA,
    ST_LAT,
    ST_DATA,
    ST_RWR
  } hb_state_t;
endpackage

// File: rtl/hbus_fsm.sv
`timescale 1ns/1ps
module hbus_fsm
  import hbus_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int RWR_W = 4,
  parameter int LAT_W = 4,
  parameter int CNT_W = LEN_W + LAT_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [LEN_W-1:0] req_len,
  input  logic [LAT_W-1:0] cfg_lat,
  input  logic             cfg_fixed,
  input  logic [RWR_W-1:0] cfg_rwr,
  input  logic             rwds_i,
  output hb_state_t        state_q,
  output logic             phase_odd,
  output logic [2:0]       ca_sel,
  output logic             req_ack
);
  hb_state_t        state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [CNT_W-1:0] lat_end_q, lat_end_d;
  logic [LAT_W+1:0] lat_cyc;
  logic [CNT_W-1:0] data_last;
  logic [CNT_W-1:0] rwr_last;
  logic             ca_last;

  // doubled latency when the mode forces it or the memory asks for it
  assign lat_cyc   = (cfg_fixed | rwds_i) ? {cfg_lat, 2'b00} : {1'b0, cfg_lat, 1'b0};
  assign data_last = CNT_W'({len_q, 1'b0}) - CNT_W'(1);
  assign rwr_last  = CNT_W'(cfg_rwr) - CNT_W'(1);
  assign ca_last   = (cnt_q == CNT_W'(CA_BYTES - 1));

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q + CNT_W'(1);
    len_d     = len_q;
    lat_end_d = lat_end_q;
    req_ack   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (req_valid) begin
          req_ack = 1'b1;
          state_d = ST_CA;
          len_d   = (req_len == '0) ? LEN_W'(1) : req_len;
        end
      end
      ST_CA: begin
        if (ca_last) begin
          cnt_d     = '0;
          lat_end_d = CNT_W'(lat_cyc) - CNT_W'(1);
          state_d   = (lat_cyc == '0) ? ST_DATA : ST_LAT;
        end
      end
      ST_LAT: begin
        if (cnt_q == lat_end_q) begin
          cnt_d   = '0;
          state_d = ST_DATA;
        end
      end
      ST_DATA: begin
        if (cnt_q == data_last) begin
          cnt_d   = '0;
          state_d = (cfg_rwr == '0) ? ST_IDLE : ST_RWR;
        end
      end
      ST_RWR: begin
        if (cnt_q == rwr_last) begin
          cnt_d   = '0;
          state_d = ST_IDLE;
        end
      end
      default: begin
        cnt_d   = '0;
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      len_q     <= '0;
      lat_end_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (req_ack) begin
        len_q <= len_d;
      end
      if (state_q == ST_CA && ca_last) begin
        lat_end_q <= lat_end_d;
      end
    end
  end

  assign phase_odd = cnt_q[0];
  assign ca_sel    = cnt_q[2:0];
endmodule

// File: rtl/hbus_ca_path.sv
`timescale 1ns/1ps
module hbus_ca_path
  import hbus_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [CA_W-1:0] ca_in,
  input  logic [2:0]      sel,
  output logic [7:0]      byte_o,
  output logic            is_read
);
  logic [CA_W-1:0] ca_q;
  logic [7:0]      ca_bytes [CA_BYTES];

  for (genvar g = 0; g < CA_BYTES; g++) begin : g_split
    assign ca_bytes[g] = ca_q[CA_W-1-8*g -: 8];
  end

  always_comb begin
    byte_o = '0;
    for (int i = 0; i < CA_BYTES; i++) begin
      if (sel == 3'(i)) byte_o = ca_bytes[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ca_q <= '0;
    end else if (load) begin
      ca_q <= ca_in;
    end
  end

  assign is_read = ca_q[CA_RD_BIT];
endmodule

// File: rtl/hbus_dpath.sv
`timescale 1ns/1ps
module hbus_dpath
  import hbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_act,
  input  logic              is_read,
  input  logic              odd,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [7:0]        dq_i,
  output logic              wr_take,
  output logic [7:0]        wr_byte,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid
);
  logic [7:0] lo_q;
  logic [7:0] hi_q;
  logic       rd_hi_en, rd_lo_en;

  assign wr_take  = data_act & ~is_read & ~odd;
  assign wr_byte  = odd ? lo_q : wr_data[15:8];
  assign rd_hi_en = data_act & is_read & ~odd;
  assign rd_lo_en = data_act & is_read & odd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q     <= '0;
      hi_q     <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (wr_take)  lo_q    <= wr_data[7:0];
      if (rd_hi_en) hi_q    <= dq_i;
      if (rd_lo_en) rd_data <= {hi_q, dq_i};
      rd_valid <= rd_lo_en;
    end
  end
endmodule

// File: rtl/hbus_seq.sv
`timescale 1ns/1ps
module hbus_seq
  import hbus_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int RWR_W = 4,
  parameter int LAT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LAT_W-1:0]  cfg_lat,
  input  logic              cfg_fixed,
  input  logic [RWR_W-1:0]  cfg_rwr,
  input  logic              req_valid,
  output logic              req_ack,
  input  logic [CA_W-1:0]   req_ca,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [WORD_W-1:0] wr_data,
  output logic              wr_take,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              cs_n,
  output logic              ck,
  output logic [7:0]        dq_o,
  output logic              dq_oe,
  input  logic [7:0]        dq_i,
  output logic              rwds_o,
  output logic              rwds_oe,
  input  logic              rwds_i
);
  localparam int CNT_W = LEN_W + LAT_W + 2;

  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  hb_state_t  state_q;
  logic       phase_odd;
  logic [2:0] ca_sel;
  logic [7:0] ca_byte, wr_byte;
  logic       is_read;
  logic       in_ca, in_lat, in_data, active, wr_data_ph;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  hbus_fsm #(
    .LEN_W(LEN_W), .RWR_W(RWR_W), .LAT_W(LAT_W), .CNT_W(CNT_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n_s), .req_valid(req_valid), .req_len(req_len),
    .cfg_lat(cfg_lat), .cfg_fixed(cfg_fixed), .cfg_rwr(cfg_rwr),
    .rwds_i(rwds_i), .state_q(state_q), .phase_odd(phase_odd),
    .ca_sel(ca_sel), .req_ack(req_ack)
  );

  hbus_ca_path u_ca (
    .clk(clk), .rst_n(rst_n_s), .load(req_ack), .ca_in(req_ca),
    .sel(ca_sel), .byte_o(ca_byte), .is_read(is_read)
  );

  assign in_ca      = (state_q == ST_CA);
  assign in_lat     = (state_q == ST_LAT);
  assign in_data    = (state_q == ST_DATA);
  assign active     = in_ca | in_lat | in_data;
  assign wr_data_ph = in_data & ~is_read;

  hbus_dpath u_dp (
    .clk(clk), .rst_n(rst_n_s), .data_act(in_data), .is_read(is_read),
    .odd(phase_odd), .wr_data(wr_data), .dq_i(dq_i), .wr_take(wr_take),
    .wr_byte(wr_byte), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  assign cs_n    = ~active;
  assign ck      = active & phase_odd;
  assign dq_oe   = in_ca | wr_data_ph;
  assign dq_o    = in_ca ? ca_byte : (wr_data_ph ? wr_byte : 8'h00);
  assign rwds_oe = wr_data_ph;
  assign rwds_o  = 1'b0;
endmodule

// File: rtl/hbus_seq_chk.sv
`timescale 1ns/1ps
module hbus_seq_chk
  import hbus_pkg::*;
#(
  parameter int RWR_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input hb_state_t        state,
  input logic             cs_n,
  input logic             ck,
  input logic             dq_oe,
  input logic             rwds_oe,
  input logic             req_ack,
  input logic             rd_valid,
  input logic             wr_take,
  input logic [RWR_W-1:0] cfg_rwr
);
  logic [RWR_W+1:0] gap_q;
  logic             seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      if (cs_n) begin
        if (gap_q != '1) gap_q <= gap_q + 1'b1;
      end else begin
        gap_q <= '0;
      end
      if (!cs_n) seen_q <= 1'b1;
    end
  end

  p_ca_dir_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CA) |-> (dq_oe && !rwds_oe));

  p_ck_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (!ck && !dq_oe && !rwds_oe));

  p_ck_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !$past(cs_n)) |-> (ck != $past(ck)));

  p_take_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |=> !wr_take);

  p_rd_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  p_ack_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> (state == ST_CA && !cs_n));

  p_recovery_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n) && seen_q) |-> (int'(gap_q) > int'(cfg_rwr)));
endmodule

bind hbus_seq hbus_seq_chk #(.RWR_W(RWR_W)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .state(state_q), .cs_n(cs_n), .ck(ck),
  .dq_oe(dq_oe), .rwds_oe(rwds_oe), .req_ack(req_ack), .rd_valid(rd_valid),
  .wr_take(wr_take), .cfg_rwr(cfg_rwr)
);

// File: tb/hbus_seq_bench.sv
`timescale 1ns/1ps
module hbus_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  cfg_lat;
  logic        cfg_fixed;
  logic [3:0]  cfg_rwr;
  logic        req_valid;
  logic        req_ack;
  logic [47:0] req_ca;
  logic [7:0]  req_len;
  logic [15:0] wr_data;
  logic        wr_take;
  logic [15:0] rd_data;
  logic        rd_valid;
  logic        cs_n, ck, dq_oe, rwds_o, rwds_oe, rwds_i;
  logic [7:0]  dq_o, dq_i;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  hbus_seq u_hbus_seq (
    .clk(clk), .rst_n(rst_n), .cfg_lat(cfg_lat), .cfg_fixed(cfg_fixed),
    .cfg_rwr(cfg_rwr), .req_valid(req_valid), .req_ack(req_ack),
    .req_ca(req_ca), .req_len(req_len), .wr_data(wr_data), .wr_take(wr_take),
    .rd_data(rd_data), .rd_valid(rd_valid), .cs_n(cs_n), .ck(ck),
    .dq_o(dq_o), .dq_oe(dq_oe), .dq_i(dq_i), .rwds_o(rwds_o),
    .rwds_oe(rwds_oe), .rwds_i(rwds_i)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int x, input int s);
    return 8'(x * 29 + s * 7 + 3);
  endfunction

  task automatic run_txn(input bit wr, input int len_in, input int lat, input bit fixed,
                         input bit rw, input int rwr, input bit check_gap, input int seed);
    int w, n, dend, waited;
    logic [47:0] ca;
    logic [15:0] wd [4];
    w    = (len_in == 0) ? 1 : len_in;
    n    = lat * 2 * ((fixed || rw) ? 2 : 1);
    dend = 7 + n + 2 * w;
    ca   = {~wr, 47'(64'h0000_1234_5678_9ABC ^ (64'(seed) * 64'h9E37_79B1))};
    for (int k = 0; k < 4; k++) wd[k] = 16'(32'hA5C3 ^ (seed * 131 + k * 911));
    cfg_lat   = 4'(lat);
    cfg_fixed = fixed;
    req_ca    = ca;
    req_len   = 8'(len_in);
    wr_data   = wd[0];
    rwds_i    = ~rw;
    req_valid = 1'b1;
    waited    = 0;
    #1;
    while (!req_ack && waited < 100) begin
      @(negedge clk);
      #1;
      waited++;
    end
    chk("R8 ack seen", req_ack, 1);
    chk("R8 cs_n high at ack", cs_n, 1);
    if (check_gap) chk("R8 recovery wait", waited, rwr);
    for (int d = 1; d <= dend; d++) begin
      @(negedge clk);
      if (d == 1) req_valid = 1'b0;
      chk("R2 ck", ck, (d < dend) ? ((d - 1) % 2) : 0);
      chk("R7 cs_n", cs_n, (d == dend) ? 1 : 0);
      if (d <= 6) begin
        chk("R1 dq_oe", dq_oe, 1);
        chk("R1 rwds_oe", rwds_oe, 0);
        chk("R1 ca byte", dq_o, ca[47 - 8 * (d - 1) -: 8]);
      end else if (d <= 6 + n) begin
        if (fixed) chk("R4 latency dq_oe", dq_oe, 0);
        else       chk("R3 latency dq_oe", dq_oe, 0);
        chk("R3 latency rwds_oe", rwds_oe, 0);
      end else if (d < dend) begin
        int j;
        j = d - 7 - n;
        if (wr) begin
          chk("R9 write dq_oe", dq_oe, 1);
          chk("R5 rwds_oe", rwds_oe, 1);
          chk("R5 mask low", rwds_o, 0);
          chk("R5 wr_take", wr_take, (j % 2 == 0) ? 1 : 0);
          chk("R5 data byte", dq_o, (j % 2 == 0) ? wd[j / 2][15:8] : wd[j / 2][7:0]);
        end else begin
          chk("R9 read dq_oe", dq_oe, 0);
          chk("R6 rwds_oe", rwds_oe, 0);
          chk("R6 no wr_take", wr_take, 0);
        end
      end else begin
        chk("R7 end dq_oe", dq_oe, 0);
        chk("R7 end rwds_oe", rwds_oe, 0);
      end
      begin
        bit ev;
        ev = !wr && d >= 9 + n && ((d - 9 - n) % 2 == 0);
        chk("R6 rd_valid", rd_valid, ev);
        if (ev) begin
          int ix;
          ix = (d - 9 - n) / 2;
          chk("R6 rd_data", rd_data, {pat(7 + n + 2 * ix, seed), pat(8 + n + 2 * ix, seed)});
        end
      end
      rwds_i = (d == 6) ? rw : ~rw;
      dq_i   = pat(d, seed);
      if (wr && d >= 8 + n && d < dend && ((d - 8 - n) % 2 == 0))
        wr_data = wd[(d - 8 - n) / 2 + 1];
    end
  endtask

  initial begin
    #900000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    int rwr_set [3];
    rwr_set[0] = 0; rwr_set[1] = 3; rwr_set[2] = 6;
    seed = 1;
    rst_n = 1'b0; cfg_lat = '0; cfg_fixed = 1'b0; cfg_rwr = '0;
    req_valid = 1'b0; req_ca = '0; req_len = '0; wr_data = '0;
    dq_i = '0; rwds_i = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R10 cs_n", cs_n, 1);
    chk("R10 ck", ck, 0);
    chk("R10 dq_oe", dq_oe, 0);
    chk("R10 rwds_oe", rwds_oe, 0);
    chk("R10 rd_valid", rd_valid, 0);
    chk("R10 wr_take", wr_take, 0);
    chk("R10 req_ack", req_ack, 0);
    for (int r = 0; r < 3; r++) begin
      bit first;
      repeat (20) @(negedge clk);
      cfg_rwr = 4'(rwr_set[r]);
      first = 1'b1;
      for (int wr = 0; wr < 2; wr++)
        for (int lat = 0; lat < 4; lat++)
          for (int w = 1; w <= 3; w++)
            for (int m = 0; m < 4; m++) begin
              run_txn(wr[0], w, lat, m[1], m[0], rwr_set[r], !first, seed);
              first = 1'b0;
              seed++;
            end
      // R11: zero length runs as one word, both directions
      run_txn(1'b1, 0, 2, 1'b0, 1'b1, rwr_set[r], 1'b1, seed);
      seed++;
      run_txn(1'b0, 0, 1, 1'b1, 1'b0, rwr_set[r], 1'b1, seed);
      seed++;
    end
    repeat (10) @(negedge clk);
    chk("R10 idle cs_n", cs_n, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule